// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Controller

This block is the device-side logic of a 64-word by 16-bit serial EEPROM reached over a three-wire, chip-select framed interface. The host raises chip select, clocks in a start bit, a two-bit opcode, a six-bit address and, for the data-carrying commands, a sixteen-bit data word. Every serial bit is sampled on a rising edge of the serial clock. The serial clock is oversampled by the block's own system clock, so every timing figure below counts system clocks.

The block answers reads with a leading zero and then the stored word, most significant bit first. Modifying commands run as a self-timed program cycle against an internal register-file array. A write-enable latch gates every modifying command. Ready/busy is shown on the data output when chip select is dropped and raised again while a cycle is running.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the data output enable is low, every word reads 16'hFFFF, and the write-enable latch is cleared.
- R2: While chip select is low, serial clocks are ignored. With chip select high, rising edges that sample data in as 0 are ignored until the first rising edge that samples a 1, which is the start bit.
- R3: Opcode 10 is READ. The rising edge that samples address bit A0 drives a 0 on the output with the enable high. Each of the next 16 rising edges presents the next stored bit, D15 first. The output changes on no other edge while chip select is high.
- R4: The output enable goes low on the rising edge after D0, or at once when chip select goes low.
- R5: WRITE (01), ERASE (11), chip erase (opcode 00, address bits [5:4]=10) and fill (opcode 00, [5:4]=01) start no program cycle and change no word unless the enable command (00, [5:4]=11) has run since reset or since the last disable command (00, [5:4]=00). A program cycle only begins with the latch set.
- R6: WRITE takes 16 data bits, MSB first, after the address. A program cycle starts then and stores the word at the address when it ends.
- R7: ERASE sets the addressed word to 16'hFFFF after a program cycle.
- R8: Chip erase sets every word to 16'hFFFF. Fill takes 16 data bits and stores them in every word. Both use the longer bulk cycle length.
- R9: If chip select goes low and then high during a program cycle, the output is enabled and shows 0 while busy and 1 once the cycle ends. If chip select stays high through the whole cycle, the output stays disabled.
- R10: Start bits that arrive during a program cycle are ignored.
- R11: After the last bit an instruction requires, further clocks and data are ignored until chip select goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; bits are sampled on its rising edge |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out: read data or ready/busy |
| dout_oe | output | 1 | Output enable for dout; low means high impedance |

## Verification
The bench goes after the edge cases of the serial framing. It sends leading zeros and clocks with chip select low before a start bit; a design that began decoding too early would misread the opcode and return the wrong word. It sends extra bits after a complete READ, and a start bit during a busy cycle; a design that rearmed its decoder would program an unrequested word, which shows up in later read-back. Modifying commands are issued with the latch cleared, and the bench checks that no busy status appears and no word changes. Chip select is held high through a cycle, and is also dropped mid-read; a wrong output-enable rule would drive the line when it should float. Constrained random command streams are compared against a bench model of the array, so a bulk-cycle or erase-value error surfaces as a miscompare.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_HDR,
    FS_DATA,
    FS_READ,
    FS_DONE
  } fstate_t;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_t;

  typedef enum logic [1:0] {
    EX_WDIS  = 2'b00,
    EX_FILL  = 2'b01,
    EX_CLEAR = 2'b10,
    EX_WEN   = 2'b11
  } ext_t;

endpackage

// File: rtl/mw_front.sv
module mw_front
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rise,
  input  logic              din,
  input  logic              busy,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic              go,
  output logic              go_all,
  output logic [ADDR_W-1:0] go_addr,
  output logic [DATA_W-1:0] go_data,
  output logic              rd_bit,
  output logic              rd_oe,
  output logic              wen,
  output logic              idle
);

  localparam int HDR_W = ADDR_W + 2;
  localparam int CW    = $clog2(DATA_W + HDR_W + 1);

  fstate_t           st_q, st_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [HDR_W-1:0]  hdr_q, hdr_n, hdr_s;
  logic [DATA_W-1:0] dat_q, dat_n, dat_s;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              bit_q, bit_n;
  logic              oe_q, oe_n;
  logic              wen_q, wen_n;

  assign hdr_s   = {hdr_q[HDR_W-2:0], din};
  assign dat_s   = {dat_q[DATA_W-2:0], din};
  assign raddr   = hdr_s[ADDR_W-1:0];
  assign go_addr = (st_q == FS_HDR) ? hdr_s[ADDR_W-1:0] : hdr_q[ADDR_W-1:0];

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    hdr_n   = hdr_q;
    dat_n   = dat_q;
    sh_n    = sh_q;
    bit_n   = bit_q;
    oe_n    = oe_q;
    wen_n   = wen_q;
    go      = 1'b0;
    go_all  = 1'b0;
    go_data = '1;
    if (!cs) begin
      st_n  = FS_IDLE;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (rise) begin
      case (st_q)
        FS_IDLE: begin
          if (din && !busy) begin
            st_n  = FS_HDR;
            cnt_n = '0;
          end
        end
        FS_HDR: begin
          hdr_n = hdr_s;
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == CW'(HDR_W - 1)) begin
            cnt_n = '0;
            st_n  = FS_DONE;
            case (op_t'(hdr_s[HDR_W-1 -: 2]))
              OP_READ: begin
                sh_n  = rdata;
                bit_n = 1'b0;
                oe_n  = 1'b1;
                st_n  = FS_READ;
              end
              OP_WRITE: st_n = FS_DATA;
              OP_ERASE: go = wen_q;
              default: begin
                case (ext_t'(hdr_s[ADDR_W-1 -: 2]))
                  EX_WEN:   wen_n = 1'b1;
                  EX_WDIS:  wen_n = 1'b0;
                  EX_CLEAR: begin
                    go     = wen_q;
                    go_all = 1'b1;
                  end
                  default:  st_n = FS_DATA;
                endcase
              end
            endcase
          end
        end
        FS_DATA: begin
          dat_n = dat_s;
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == CW'(DATA_W - 1)) begin
            st_n    = FS_DONE;
            go      = wen_q;
            go_all  = (op_t'(hdr_q[HDR_W-1 -: 2]) == OP_EXT);
            go_data = dat_s;
          end
        end
        FS_READ: begin
          if (cnt_q == CW'(DATA_W)) begin
            oe_n = 1'b0;
            st_n = FS_DONE;
          end else begin
            bit_n = sh_q[DATA_W-1];
            sh_n  = {sh_q[DATA_W-2:0], 1'b0};
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_IDLE;
      cnt_q <= '0;
      hdr_q <= '0;
      dat_q <= '0;
      sh_q  <= '0;
      bit_q <= 1'b0;
      oe_q  <= 1'b0;
      wen_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      hdr_q <= hdr_n;
      dat_q <= dat_n;
      sh_q  <= sh_n;
      bit_q <= bit_n;
      oe_q  <= oe_n;
      wen_q <= wen_n;
    end
  end

  assign rd_bit = bit_q;
  assign rd_oe  = oe_q;
  assign wen    = wen_q;
  assign idle   = (st_q == FS_IDLE);

endmodule

// File: rtl/mw_ptimer.sv
module mw_ptimer #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int PROG_CYC = 200,
  parameter int BULK_CYC = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_all,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_data,
  output logic              busy,
  output logic              commit,
  output logic              c_all,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data
);

  localparam int TW = $clog2(BULK_CYC + 1);

  logic [TW-1:0]     cnt_q, cnt_n;
  logic              all_q, all_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] data_q, data_n;

  always_comb begin
    cnt_n  = cnt_q;
    all_n  = all_q;
    addr_n = addr_q;
    data_n = data_q;
    if (go) begin
      cnt_n  = go_all ? TW'(BULK_CYC) : TW'(PROG_CYC);
      all_n  = go_all;
      addr_n = go_addr;
      data_n = go_data;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      all_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      cnt_q  <= cnt_n;
      all_q  <= all_n;
      addr_q <= addr_n;
      data_q <= data_n;
    end
  end

  assign busy   = (cnt_q != '0);
  assign commit = (cnt_q == TW'(1));
  assign c_all  = all_q;
  assign c_addr = addr_q;
  assign c_data = data_q;

endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              c_all,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_data,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic we;
    assign we = commit && (c_all || (c_addr == ADDR_W'(w)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[w] <= '1;
      end else if (we) begin
        mem_q[w] <= c_data;
      end
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int PROG_CYC = 200,
  parameter int BULK_CYC = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic din,
  output logic dout,
  output logic dout_oe
);

  logic              sclk_q;
  logic              rise;
  logic              armed_q, armed_n;
  logic              busy, commit, c_all;
  logic [ADDR_W-1:0] c_addr, raddr, go_addr;
  logic [DATA_W-1:0] c_data, rdata, go_data;
  logic              go, go_all;
  logic              rd_bit, rd_oe, wen, fe_idle;
  logic              show_stat;

  assign rise = sclk && !sclk_q;

  always_comb begin
    armed_n = armed_q;
    if (!cs) begin
      armed_n = busy;
    end else if (!fe_idle) begin
      armed_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      armed_q <= armed_n;
    end
  end

  mw_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rise(rise), .din(din), .busy(busy),
    .rdata(rdata), .raddr(raddr), .go(go), .go_all(go_all), .go_addr(go_addr),
    .go_data(go_data), .rd_bit(rd_bit), .rd_oe(rd_oe), .wen(wen), .idle(fe_idle)
  );

  mw_ptimer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYC(PROG_CYC),
              .BULK_CYC(BULK_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(go), .go_all(go_all), .go_addr(go_addr),
    .go_data(go_data), .busy(busy), .commit(commit), .c_all(c_all),
    .c_addr(c_addr), .c_data(c_data)
  );

  mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit), .c_all(c_all), .c_addr(c_addr),
    .c_data(c_data), .raddr(raddr), .rdata(rdata)
  );

  assign show_stat = armed_q && fe_idle;
  assign dout      = show_stat ? !busy : rd_bit;
  assign dout_oe   = cs && (show_stat || rd_oe);

endmodule

// File: rtl/mw_eeprom_slave_chk.sv
module mw_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic rise,
  input logic dout,
  input logic dout_oe,
  input logic busy,
  input logic wen,
  input logic idle
);

  // R5
  prog_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));

  // R5
  wen_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wen) |-> $past(cs));

  // R10
  busy_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idle) |=> idle);

  // R3
  dout_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe) && cs && $past(cs) && !$past(rise) && $stable(busy))
      |-> $stable(dout));

  // R4
  oe_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> ($past(rise) || !$past(cs)));

endmodule

bind mw_eeprom_slave mw_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rise(rise), .dout(dout),
  .dout_oe(dout_oe), .busy(busy), .wen(wen), .idle(fe_idle)
);

// File: tb/mw_eeprom_slave_test.sv
module mw_eeprom_slave_test;

  localparam int PROG = 200;
  localparam int BULK = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, din = 1'b0;
  logic dout, dout_oe;
  int   nvec = 0, nerr = 0;
  logic so_do, so_oe;
  logic [15:0] mdl [64];
  logic wen_m;

  always #10 clk = ~clk;

  mw_eeprom_slave #(.PROG_CYC(PROG), .BULK_CYC(BULK)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [15:0] exp_word(input int a);
    return mdl[a];
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    @(negedge clk); sclk = 1'b0; din = b;
    @(negedge clk); sclk = 1'b1;
    @(negedge clk); so_do = dout; so_oe = dout_oe;
  endtask

  task automatic begin_cmd();
    @(negedge clk); cs = 1'b1; sclk = 1'b0; din = 1'b0;
  endtask

  task automatic end_cmd();
    @(negedge clk); cs = 1'b0; sclk = 1'b0; din = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] op, input logic [5:0] a,
                            input logic has_d, input logic [15:0] d);
    sbit(1'b1);
    for (int i = 1; i >= 0; i--) sbit(op[i]);
    for (int i = 5; i >= 0; i--) sbit(a[i]);
    if (has_d) for (int i = 15; i >= 0; i--) sbit(d[i]);
  endtask

  task automatic instr(input logic [1:0] op, input logic [5:0] a,
                       input logic has_d, input logic [15:0] d);
    begin_cmd();
    send_frame(op, a, has_d, d);
    end_cmd();
  endtask

  task automatic rd(input int a, input string tag);
    logic [15:0] got;
    begin_cmd();
    sbit(1'b1); sbit(1'b1); sbit(1'b0);
    for (int i = 5; i >= 0; i--) sbit(a[i]);
    chk(so_oe && !so_do, "R3 dummy zero", {14'd0, so_oe, so_do}, 16'h2);
    for (int i = 15; i >= 0; i--) begin
      sbit(1'b0);
      got[i] = so_do;
    end
    sbit(1'b0);
    chk(!so_oe, "R4 oe after D0", {15'd0, so_oe}, 16'h0);
    end_cmd();
    chk(got == exp_word(a), tag, got, exp_word(a));
  endtask

  task automatic wait_ready(input logic expect_busy);
    logic seen;
    @(negedge clk); cs = 1'b0; sclk = 1'b0; din = 1'b0;
    @(negedge clk); @(negedge clk); cs = 1'b1;
    @(negedge clk);
    chk(dout_oe, "R9 status enabled", {15'd0, dout_oe}, 16'h1);
    if (expect_busy) chk(!dout, "R9 busy shows 0", {15'd0, dout}, 16'h0);
    seen = 1'b0;
    for (int i = 0; i < BULK + 100 && !seen; i++) begin
      @(negedge clk);
      seen = dout_oe && dout;
    end
    chk(seen, "R9 ready shows 1", {15'd0, seen}, 16'h1);
    end_cmd();
  endtask

  task automatic no_status(input string tag);
    @(negedge clk); cs = 1'b0;
    @(negedge clk); @(negedge clk); cs = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!dout_oe, tag, {15'd0, dout_oe}, 16'h0);
    end_cmd();
  endtask

  task automatic prog(input logic [1:0] op, input logic [5:0] a,
                      input logic has_d, input logic [15:0] d);
    instr(op, a, has_d, d);
    if (wen_m) begin
      if (op == 2'b01) mdl[a] = d;
      else if (op == 2'b11) mdl[a] = 16'hFFFF;
      else if (a[5:4] == 2'b10) for (int i = 0; i < 64; i++) mdl[i] = 16'hFFFF;
      else for (int i = 0; i < 64; i++) mdl[i] = d;
      wait_ready(1'b1);
    end else begin
      no_status("R5 no cycle while disabled");
    end
  endtask

  task automatic set_wen(input logic en);
    instr(2'b00, en ? 6'b110000 : 6'b000000, 1'b0, 16'h0);
    wen_m = en;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin : main
    int oe_hits;
    void'($urandom(32'd1971));
    for (int i = 0; i < 64; i++) mdl[i] = 16'hFFFF;
    wen_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!dout_oe, "R1 oe low after reset", {15'd0, dout_oe}, 16'h0);
    rd(0, "R1 word 0 erased");
    rd(63, "R1 word 63 erased");
    // R5 write while disabled
    prog(2'b01, 6'd5, 1'b1, 16'h1234);
    rd(5, "R5 disabled write ignored");

    // R2 clocks with cs low, then leading zeros
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); din = 1'b1; sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
    end
    din = 1'b0;
    set_wen(1'b1);
    begin_cmd();
    sbit(1'b0); sbit(1'b0); sbit(1'b0);
    send_frame(2'b01, 6'd7, 1'b1, 16'hBEEF);
    end_cmd();
    mdl[7] = 16'hBEEF;
    wait_ready(1'b1);
    rd(7, "R2 leading zeros before start");

    // R6 write and read back
    prog(2'b01, 6'd5, 1'b1, 16'hA5C3);
    rd(5, "R6 write stored");

    // R4 cs falls mid read
    begin_cmd();
    sbit(1'b1); sbit(1'b1); sbit(1'b0);
    for (int i = 5; i >= 0; i--) sbit(1'b0);
    sbit(1'b0); sbit(1'b0);
    @(negedge clk); cs = 1'b0;
    #1 chk(!dout_oe, "R4 oe drops with cs", {15'd0, dout_oe}, 16'h0);
    @(negedge clk);

    // R9 cs held high through the cycle
    begin_cmd();
    send_frame(2'b01, 6'd9, 1'b1, 16'h0F0F);
    mdl[9] = 16'h0F0F;
    oe_hits = 0;
    for (int i = 0; i < PROG + 20; i++) begin
      @(negedge clk);
      if (dout_oe) oe_hits++;
    end
    chk(oe_hits == 0, "R9 no status with cs high", 16'(oe_hits), 16'h0);
    end_cmd();
    rd(9, "R9 write completed");

    // R10 start during busy
    instr(2'b01, 6'd10, 1'b1, 16'h5555);
    mdl[10] = 16'h5555;
    @(negedge clk); @(negedge clk);
    begin_cmd();
    send_frame(2'b01, 6'd11, 1'b1, 16'h0000);
    end_cmd();
    repeat (PROG + 50) @(negedge clk);
    rd(11, "R10 start while busy ignored");
    rd(10, "R10 first write intact");

    // R11 trailing bits after a complete read
    begin_cmd();
    sbit(1'b1); sbit(1'b1); sbit(1'b0);
    for (int i = 5; i >= 0; i--) sbit(1'b0);
    for (int i = 0; i < 17; i++) sbit(1'b0);
    send_frame(2'b01, 6'd3, 1'b1, 16'h0000);
    chk(!so_oe, "R11 trailing bits no output", {15'd0, so_oe}, 16'h0);
    end_cmd();
    no_status("R11 no cycle from trailing bits");
    rd(3, "R11 word unchanged");

    // R7 erase
    prog(2'b01, 6'd20, 1'b1, 16'h1357);
    rd(20, "R6 word 20 written");
    prog(2'b11, 6'd20, 1'b0, 16'h0);
    rd(20, "R7 erase to ones");

    // R8 fill and chip erase
    prog(2'b00, 6'b010000, 1'b1, 16'h2468);
    rd(0, "R8 fill word 0");
    rd(42, "R8 fill word 42");
    prog(2'b00, 6'b100000, 1'b0, 16'h0);
    rd(5, "R8 chip erase word 5");
    rd(63, "R8 chip erase word 63");

    // R5 disable again
    prog(2'b01, 6'd1, 1'b1, 16'hCAFE);
    set_wen(1'b0);
    prog(2'b00, 6'b100000, 1'b0, 16'h0);
    prog(2'b11, 6'd1, 1'b0, 16'h0);
    rd(1, "R5 disabled erase ignored");

    // random mix
    for (int k = 0; k < 40; k++) begin
      int r;
      logic [5:0] a;
      logic [15:0] d;
      r = int'($urandom % 11);
      a = 6'($urandom);
      d = 16'($urandom);
      case (r)
        0, 1, 2, 3: rd(a, "R3 random read");
        4, 5:       prog(2'b01, a, 1'b1, d);
        6:          prog(2'b11, a, 1'b0, 16'h0);
        7, 8:       set_wen(1'b1);
        9:          set_wen(1'b0);
        default:    if (d[0]) prog(2'b00, 6'b010000, 1'b1, d);
                    else prog(2'b00, 6'b100000, 1'b0, 16'h0);
      endcase
    end
    rd(0, "R6 final word 0");
    rd(33, "R6 final word 33");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule